// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block governs the exit from a halted, clock-stopped state in a small microcontroller core. When the core requests a halt, the sequencer drops its clock-run enable. It then watches two kinds of event. The first is a falling edge on any pin of an 8-bit input port whose wake-enable bit is set. The second is an interrupt request line that rises during the halt. A request that was already set when the halt began is not counted as an event.

When an event arrives, the clock is restarted and a fixed settling delay of 1024 cycles is counted. At the end of the delay the sequencer tells the core how to continue. The core either executes the instruction after the halt, or vectors to the interrupt that caused the wake. It vectors only when that interrupt is enabled and the stack has room. When several requests qualify, the lowest-numbered enabled one is taken. A request that is not vectored stays pending in the core, which services it later.

Top module: `pdw_top`

## Requirements
- R1: After reset the clock-run enable is 1 and both the resume-next and take-interrupt pulses are 0.
- R2: A halt request while running drives the clock-run enable to 0 at the next clock edge, and it stays 0 until a qualifying wake event.
- R3: A falling edge on a port pin wakes the block only when that pin's wake-enable bit is set. A fall on a pin whose bit is clear leaves the clock stopped.
- R4: A pin falling edge that happens while the block is running is ignored. It does not cause a wake after a later halt.
- R5: A rising edge on a port pin never causes a wake.
- R6: An interrupt request that is already 1 when the halt begins does not wake the block. If a pin then wakes the block, the result is a resume-next.
- R7: An interrupt request that rises during the halt wakes the block even when its enable bit is 0. In that case the result is a resume-next.
- R8: When the waking requests include an enabled one and the stack-full input is 0, a take-interrupt pulse is produced. The index output gives the lowest-numbered request that is both waking and enabled. Index i stands for request line i.
- R9: When the stack-full input is 1 at the end of the delay, an interrupt wake gives a resume-next instead of a take-interrupt.
- R10: The resume-next pulse comes exactly 1024 clock edges after the clock-run enable returns to 1. The take-interrupt pulse comes one edge later than that, at 1025.
- R11: Each wake produces exactly one single-cycle pulse, and resume-next and take-interrupt are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| haltReq | input | 1 | One-cycle request from the core to enter the halted state |
| portPins | input | 8 | Asynchronous input port; idle level is high |
| pinWakeEn | input | 8 | Per-pin wake enable |
| irqReq | input | 4 | Interrupt request flags |
| irqEn | input | 4 | Interrupt enable bits |
| stackFull | input | 1 | Core stack has no free level |
| clkRun | output | 1 | Core clock enable; 0 while halted |
| resumeNext | output | 1 | One-cycle pulse: continue at the instruction after the halt |
| takeIrq | output | 1 | One-cycle pulse: vector to the interrupt given by irqIdx |
| irqIdx | output | 2 | Index of the interrupt to vector to; valid with takeIrq |

## Verification
The hardest situation to reach is a wake in which an interrupt line is set but must still not be vectored. This happens in two ways. In one, the flag was already high when the halt began. In the other, the line is high but masked by its enable while a higher-numbered enabled line is also waking. The stimulus raises a request before issuing the halt and waits to confirm the clock stays off. It then wakes through a pin and expects a resume-next. It also raises two requests together under a partial enable mask and expects the index of the enabled one, not the lowest line.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN,
    SEQ_HALT,
    SEQ_SETTLE,
    SEQ_VECTOR
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureBlock;  // halt entry: remember requests already pending
    logic captureWake;   // wake edge: remember waking requests, clear delay counter
    logic cntRun;        // settling delay advances
    logic latchVec;      // end of delay: freeze the vector index
  } seqStrobe_t;

endpackage

// File: rtl/pdw_pinedge.sv
module pdw_pinedge #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] pinsAsync,
  output logic [PINS-1:0] pinFall
);

  for (genvar p = 0; p < PINS; p++) begin : gPin
    logic meta, sync, prev;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta <= 1'b1;
        sync <= 1'b1;
        prev <= 1'b1;
      end else begin
        meta <= pinsAsync[p];
        sync <= meta;
        prev <= sync;
      end
    end
    assign pinFall[p] = prev & ~sync;
  end

endmodule

// File: rtl/pdw_datapath.sv
module pdw_datapath
  import pdw_pkg::*;
#(
  parameter int PINS  = 8,
  parameter int NIRQ  = 4,
  parameter int DELAY = 1024
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic [PINS-1:0]       pinFall,
  input  logic [PINS-1:0]       pinWakeEn,
  input  logic [NIRQ-1:0]       irqReq,
  input  logic [NIRQ-1:0]       irqEn,
  input  logic                  stackFull,
  output logic                  wakeEvt,
  output logic                  cntDone,
  output logic                  vecOk,
  output logic [$clog2(NIRQ > 1 ? NIRQ : 2)-1:0] vecIdx
);

  localparam int CNTW = $clog2(DELAY + 1);
  localparam int IDXW = $clog2(NIRQ > 1 ? NIRQ : 2);

  logic [NIRQ-1:0] blockMask;
  logic [NIRQ-1:0] wakeMask;
  logic [NIRQ-1:0] cand;
  logic [CNTW-1:0] cnt;
  logic [IDXW-1:0] candIdx;

  // a request pending at halt entry stays blocked until it drops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     blockMask <= '0;
    else if (strobe.captureBlock)  blockMask <= irqReq;
    else                           blockMask <= blockMask & irqReq;
  end

  assign wakeEvt = (|(pinFall & pinWakeEn)) | (|(irqReq & ~blockMask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeMask <= '0;
      cnt      <= '0;
    end else if (strobe.captureWake) begin
      wakeMask <= irqReq & ~blockMask;
      cnt      <= '0;
    end else if (strobe.cntRun) begin
      cnt      <= cnt + 1'b1;
    end
  end

  assign cntDone = (cnt == CNTW'(DELAY - 1));
  assign cand    = wakeMask & irqEn;
  assign vecOk   = (|cand) & ~stackFull;

  always_comb begin
    candIdx = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (cand[i]) candIdx = IDXW'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                vecIdx <= '0;
    else if (strobe.latchVec) vecIdx <= candIdx;
  end

endmodule

// File: rtl/pdw_ctrl.sv
module pdw_ctrl
  import pdw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltReq,
  input  logic       wakeEvt,
  input  logic       cntDone,
  input  logic       vecOk,
  output seqStrobe_t strobe,
  output logic       clkRun,
  output logic       resumeNext,
  output logic       takeIrq
);

  seqState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      SEQ_RUN: begin
        if (haltReq) begin
          stateNxt            = SEQ_HALT;
          strobe.captureBlock = 1'b1;
        end
      end
      SEQ_HALT: begin
        if (wakeEvt) begin
          stateNxt           = SEQ_SETTLE;
          strobe.captureWake = 1'b1;
        end
      end
      SEQ_SETTLE: begin
        strobe.cntRun = 1'b1;
        if (cntDone) begin
          strobe.latchVec = 1'b1;
          stateNxt        = vecOk ? SEQ_VECTOR : SEQ_RUN;
        end
      end
      SEQ_VECTOR: stateNxt = SEQ_RUN;
      default:    stateNxt = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= SEQ_RUN;
      resumeNext <= 1'b0;
      takeIrq    <= 1'b0;
    end else begin
      state      <= stateNxt;
      resumeNext <= (state == SEQ_SETTLE) && cntDone && !vecOk;
      takeIrq    <= (state == SEQ_VECTOR);
    end
  end

  assign clkRun = (state != SEQ_HALT);

endmodule

// File: rtl/pdw_top.sv
module pdw_top
  import pdw_pkg::*;
#(
  parameter int PINS  = 8,
  parameter int NIRQ  = 4,
  parameter int DELAY = 1024,
  localparam int IDXW = $clog2(NIRQ > 1 ? NIRQ : 2)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            haltReq,
  input  logic [PINS-1:0] portPins,
  input  logic [PINS-1:0] pinWakeEn,
  input  logic [NIRQ-1:0] irqReq,
  input  logic [NIRQ-1:0] irqEn,
  input  logic            stackFull,
  output logic            clkRun,
  output logic            resumeNext,
  output logic            takeIrq,
  output logic [IDXW-1:0] irqIdx
);

  seqStrobe_t      strobe;
  logic [PINS-1:0] pinFall;
  logic            wakeEvt, cntDone, vecOk;

  pdw_pinedge #(.PINS(PINS)) uEdge (
    .clk(clk), .rstN(rstN), .pinsAsync(portPins), .pinFall(pinFall)
  );

  pdw_datapath #(.PINS(PINS), .NIRQ(NIRQ), .DELAY(DELAY)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pinFall(pinFall),
    .pinWakeEn(pinWakeEn), .irqReq(irqReq), .irqEn(irqEn),
    .stackFull(stackFull), .wakeEvt(wakeEvt), .cntDone(cntDone),
    .vecOk(vecOk), .vecIdx(irqIdx)
  );

  pdw_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .wakeEvt(wakeEvt),
    .cntDone(cntDone), .vecOk(vecOk), .strobe(strobe), .clkRun(clkRun),
    .resumeNext(resumeNext), .takeIrq(takeIrq)
  );

endmodule

// File: rtl/pdw_check.sv
module pdw_check #(
  parameter int DELAY = 1024
) (
  input logic clk,
  input logic rstN,
  input logic haltReq,
  input logic clkRun,
  input logic resumeNext,
  input logic takeIrq
);

  // edges seen since the clock-run enable came back
  int   runCnt;
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= 0;
      armed  <= 1'b0;
    end else if (!clkRun) begin
      runCnt <= 0;
      armed  <= 1'b1;
    end else if (runCnt < DELAY + 4) begin
      runCnt <= runCnt + 1;
    end
  end

  assert_pulse_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({resumeNext, takeIrq}) <= 1);

  assert_resume_delay_R10: assert property (@(posedge clk) disable iff (!rstN)
    resumeNext |-> (armed && runCnt == DELAY));

  assert_vector_delay_R10: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (armed && runCnt == DELAY + 1));

  assert_stop_on_halt_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkRun) |-> $past(haltReq));

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    resumeNext |=> !resumeNext);

endmodule

bind pdw_top pdw_check #(.DELAY(DELAY)) uCheck (
  .clk(clk), .rstN(rstN), .haltReq(haltReq), .clkRun(clkRun),
  .resumeNext(resumeNext), .takeIrq(takeIrq)
);

// File: tb/pdw_top_test.sv
module pdw_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int DELAY      = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       haltReq = 1'b0;
  logic [7:0] portPins = 8'hFF;
  logic [7:0] pinWakeEn = 8'h00;
  logic [3:0] irqReq = 4'h0;
  logic [3:0] irqEn = 4'h0;
  logic       stackFull = 1'b0;
  logic       clkRun, resumeNext, takeIrq;
  logic [1:0] irqIdx;

  int checks = 0;
  int errors = 0;

  typedef struct { bit isVec; int idx; string tag; } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pdw_top uut (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .portPins(portPins),
    .pinWakeEn(pinWakeEn), .irqReq(irqReq), .irqEn(irqEn),
    .stackFull(stackFull), .clkRun(clkRun), .resumeNext(resumeNext),
    .takeIrq(takeIrq), .irqIdx(irqIdx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endfunction

  // monitor: compares each resume decision with the queue head
  int runCnt = 0;
  always @(negedge clk) begin
    if (!rstN || !clkRun) runCnt = 0;
    else runCnt++;
    if (rstN && (resumeNext || takeIrq)) begin
      check(!(resumeNext && takeIrq), "R11 both pulses", 2, 1);
      if (expQ.size() == 0) begin
        check(1'b0, "R11 unexpected pulse", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(takeIrq == e.isVec, {e.tag, " kind(takeIrq)"}, int'(takeIrq), int'(e.isVec));
        check(runCnt - 1 == (e.isVec ? DELAY + 1 : DELAY), "R10 latency",
              runCnt - 1, e.isVec ? DELAY + 1 : DELAY);
        if (e.isVec) check(int'(irqIdx) == e.idx, {e.tag, " index"}, int'(irqIdx), e.idx);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hang expected=done");
    finishRun();
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enterHalt();
    haltReq = 1'b1;
    cycles(1);
    haltReq = 1'b0;
    check(clkRun == 1'b0, "R2 clock stops", int'(clkRun), 0);
  endtask

  task automatic expectWake(input bit isVec, input int idx, input string tag);
    expItem_t e;
    e.isVec = isVec; e.idx = idx; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic waitDone();
    while (expQ.size() != 0) cycles(1);
    cycles(3);
    check(clkRun == 1'b1, "R11 running after wake", int'(clkRun), 1);
  endtask

  task automatic stayHalted(input string tag);
    cycles(30);
    check(clkRun == 1'b0, tag, int'(clkRun), 0);
  endtask

  initial begin
    cycles(3);
    rstN = 1'b1;
    cycles(1);
    check(clkRun == 1'b1, "R1 clkRun", int'(clkRun), 1);
    check(resumeNext == 1'b0, "R1 resumeNext", int'(resumeNext), 0);
    check(takeIrq == 1'b0, "R1 takeIrq", int'(takeIrq), 0);

    // R3: enabled pin wakes, resume at next instruction
    pinWakeEn = 8'h08;
    enterHalt();
    expectWake(1'b0, 0, "R3 pin wake");
    portPins[3] = 1'b0;
    waitDone();
    portPins[3] = 1'b1;
    cycles(5);

    // R3 disabled pin, R5 rising edge
    enterHalt();
    portPins[5] = 1'b0;
    stayHalted("R3 disabled pin");
    portPins[5] = 1'b1;
    stayHalted("R5 rising edge");
    expectWake(1'b0, 0, "R3 pin wake after ignored");
    portPins[3] = 1'b0;
    waitDone();
    portPins[3] = 1'b1;
    cycles(5);

    // R4: fall while running is forgotten
    portPins[3] = 1'b0;
    cycles(10);
    enterHalt();
    stayHalted("R4 fall during run");
    portPins[3] = 1'b1;
    stayHalted("R5 rising in halt");
    expectWake(1'b0, 0, "R4 later fall");
    portPins[3] = 1'b0;
    waitDone();
    portPins[3] = 1'b1;
    cycles(5);

    // R6: request pending at halt entry
    irqEn = 4'hF;
    irqReq = 4'b0010;
    cycles(2);
    enterHalt();
    stayHalted("R6 pending request");
    expectWake(1'b0, 0, "R6 pin wake with stale flag");
    portPins[3] = 1'b0;
    waitDone();
    portPins[3] = 1'b1;
    irqReq = 4'h0;
    cycles(5);

    // R7: disabled interrupt wakes, resumes next
    irqEn = 4'h0;
    enterHalt();
    expectWake(1'b0, 0, "R7 disabled irq");
    irqReq = 4'b0100;
    waitDone();
    irqReq = 4'h0;
    cycles(5);

    // R8: lowest enabled wins
    irqEn = 4'hF;
    enterHalt();
    expectWake(1'b1, 1, "R8 lowest");
    irqReq = 4'b1010;
    waitDone();
    irqReq = 4'h0;
    cycles(5);

    irqEn = 4'b1000;
    enterHalt();
    expectWake(1'b1, 3, "R8 masked lower");
    irqReq = 4'b1010;
    waitDone();
    irqReq = 4'h0;
    cycles(5);

    // R9: stack full keeps request pending
    irqEn = 4'hF;
    stackFull = 1'b1;
    enterHalt();
    expectWake(1'b0, 0, "R9 stack full");
    irqReq = 4'b0100;
    waitDone();
    irqReq = 4'h0;
    stackFull = 1'b0;
    cycles(5);

    check(expQ.size() == 0, "R11 queue drained", expQ.size(), 0);
    finishRun();
  end

endmodule